// File: doc/BRIEF.md
# DMA Channel Width Adapter

This block sits on one DMA channel between the data port that reads from the source and the data port that writes to the destination. It takes a stream of source beats of one width (8, 16 or 32 bits) and produces a stream of destination beats of another width. Narrow items are packed into wider words and wide words are split into narrow items. Bytes keep their order. The earliest byte always lands in the lowest byte lane. The direction input selects which side is the source. The item count and widths are captured in the cycle after the channel is enabled. When the stream ends with a destination word that is not full, that word is sent with byte enables only on the bytes that hold data.

Software programs the two widths, the mode, the direction and the item count, then raises the channel enable. The source handshakes beats in through `in_valid`/`in_ready`. The destination takes beats through `out_valid`/`out_ready`. Address generation, bus protocol and arbitration are handled elsewhere.

Top module: `dma_width_adapter`

## Requirements
- R1: The width fields encode 2'b00 as 1 byte, 2'b01 as 2 bytes and 2'b10 as 4 bytes. The reserved code 2'b11 behaves as 4 bytes. Source lanes above the source width are ignored.
- R2: With multi-data mode set and different widths, bytes arrive at the destination in the order they entered. The first byte of each destination beat sits in lane 0 (bits 7:0), followed by lanes 1, 2 and 3.
- R3: With multi-data mode clear, the memory width field is ignored and the memory side runs at the peripheral width, so every beat carries exactly the peripheral-width bytes.
- R4: The bytes delivered in one transfer number exactly item_count times the peripheral byte size. No beat appears beyond that.
- R5: While the source still owes bytes, a partly filled destination word is held back. Once the last source byte is taken, that word is emitted with enables only on its filled lanes.
- R6: The holding register stores at most eight bytes. `in_ready` is low whenever the next source beat would not fit, so with the destination stalled an 8-bit source is accepted exactly eight times.
- R7: Dropping `ch_en` empties the holding register within one clock. Bytes taken before the drop never reach the destination, including after a later re-enable.
- R8: `out_be` is a contiguous run of ones starting at lane 0, no wider than the destination width. Lanes whose enable is low carry zero.
- R9: With `mem_is_src` set, memory beats of the memory width enter and peripheral-width items leave. The tail of the last memory word beyond the byte total is dropped.
- R10: Configuration inputs, item count included, are sampled once when the channel starts. Changing them during a transfer has no effect on its output.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `out_be` hold their values.
- R12: After reset, and whenever the byte total is used up (including an item count of zero), `in_ready` and `out_valid` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ch_en | input | 1 | Channel enable. A rising level starts a transfer; low flushes the channel |
| multi_mode | input | 1 | 1: widths independent (packing); 0: memory width follows peripheral width |
| mem_is_src | input | 1 | 1: memory is source, peripheral is destination |
| per_width | input | 2 | Peripheral item width code |
| mem_width | input | 2 | Memory word width code |
| item_count | input | CNT_W | Number of peripheral-width items in the transfer |
| in_valid | input | 1 | Source beat valid |
| in_ready | output | 1 | Adapter can take a source beat |
| in_data | input | 32 | Source beat, right-aligned in lane 0 upward |
| out_valid | output | 1 | Destination beat valid |
| out_ready | input | 1 | Destination takes the beat |
| out_data | output | 32 | Destination beat, lane 0 first |
| out_be | output | 4 | Byte enables of the destination beat |

## Verification
The hardest situation to reach is a destination stall while the holding register is close to full and the source keeps offering beats. This is where the eight-byte limit and the stable-beat rule both apply. The bench reaches it in two ways. It pins `out_ready` low during an 8-bit to 32-bit transfer while counting accepted beats. It also uses a pseudo-random ready pattern on every other transfer. A second hard case is a partial word left in the buffer when the channel drops. The bench stops feeding part-way through a word, removes the enable, then runs a fresh transfer whose expected words would be corrupted by any stale byte.

// File: rtl/dma_wa_pkg.sv
// Package: shared width codes and helpers for the DMA width adapter.
// Assumes a 32-bit data path split into four byte lanes.
package dma_wa_pkg;

    localparam int LANES = 4;
    localparam int BC_W  = $clog2(LANES + 1);

    typedef enum logic [1:0] {
        WSEL_8   = 2'b00,
        WSEL_16  = 2'b01,
        WSEL_32  = 2'b10,
        WSEL_RSV = 2'b11
    } wsel_e;

    // Byte size of a width code; the reserved code counts as a full word.
    function automatic logic [BC_W-1:0] width_bytes(input logic [1:0] code);
        case (wsel_e'(code))
            WSEL_8:  width_bytes = BC_W'(1);
            WSEL_16: width_bytes = BC_W'(2);
            default: width_bytes = BC_W'(4);
        endcase
    endfunction

    // Log2 of the byte size, used to scale an item count to bytes.
    function automatic logic [1:0] width_shift(input logic [1:0] code);
        case (wsel_e'(code))
            WSEL_8:  width_shift = 2'd0;
            WSEL_16: width_shift = 2'd1;
            default: width_shift = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/wa_cfg_capture.sv
// Configuration capture: samples widths, mode and direction when the
// channel starts and holds them until the enable drops. In single-data
// mode the memory width is replaced by the peripheral width.
// Assumes ch_en stays low for at least one clock between transfers.
module wa_cfg_capture
    import dma_wa_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int TOT_W = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_en,
    input  logic             multi_mode,
    input  logic             mem_is_src,
    input  logic [1:0]       per_width,
    input  logic [1:0]       mem_width,
    input  logic [CNT_W-1:0] item_count,
    output logic             active,
    output logic             start,
    output logic [TOT_W-1:0] total_now,
    output logic [BC_W-1:0]  src_bytes,
    output logic [BC_W-1:0]  dst_bytes
);

    logic            active_q;
    logic            multi_q;
    logic            dir_q;
    logic [BC_W-1:0] per_b_q;
    logic [BC_W-1:0] mem_b_q;

    // Start pulse: enable seen high while the channel is still idle.
    assign start     = ch_en && !active_q;
    assign total_now = TOT_W'(item_count) << width_shift(per_width);

    // Capture configuration once per transfer; clear on disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            multi_q  <= 1'b0;
            dir_q    <= 1'b0;
            per_b_q  <= BC_W'(1);
            mem_b_q  <= BC_W'(1);
        end else if (!ch_en) begin
            active_q <= 1'b0;
        end else if (start) begin
            active_q <= 1'b1;
            multi_q  <= multi_mode;
            dir_q    <= mem_is_src;
            per_b_q  <= width_bytes(per_width);
            mem_b_q  <= multi_mode ? width_bytes(mem_width) : width_bytes(per_width);
        end
    end

    assign active    = active_q;
    assign src_bytes = dir_q ? mem_b_q : per_b_q;
    assign dst_bytes = dir_q ? per_b_q : mem_b_q;

    // R3: single-data mode runs both sides at the peripheral width.
    p_single_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !multi_q) |-> (mem_b_q == per_b_q));

    // R10: captured fields do not move while the channel stays active.
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && $past(active_q)) |->
            ($stable(per_b_q) && $stable(mem_b_q) && $stable(dir_q) && $stable(multi_q)));

endmodule

// File: rtl/wa_in_tracker.sv
// Source byte tracker: counts the bytes the source still owes and sizes
// each accepted beat, trimming the final beat to the remaining bytes.
// Assumes start and in_fire are never high together.
module wa_in_tracker
    import dma_wa_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int TOT_W = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_en,
    input  logic             start,
    input  logic [TOT_W-1:0] total_now,
    input  logic [BC_W-1:0]  src_bytes,
    input  logic             in_fire,
    output logic             rem_zero,
    output logic [BC_W-1:0]  take_bytes
);

    logic [TOT_W-1:0] rem_q;

    // Bytes taken from the next beat: a full source beat or the tail.
    always_comb begin
        if (rem_q >= TOT_W'(src_bytes)) take_bytes = src_bytes;
        else                            take_bytes = rem_q[BC_W-1:0];
    end

    assign rem_zero = (rem_q == '0);

    // Load the byte total at start, count down on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n)       rem_q <= '0;
        else if (!ch_en)  rem_q <= '0;
        else if (start)   rem_q <= total_now;
        else if (in_fire) rem_q <= rem_q - TOT_W'(take_bytes);
    end

    // R4: an accepted beat always moves at least one byte and no more than the width.
    p_take_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |-> ((take_bytes != '0) && (take_bytes <= src_bytes)));

    // R4: the remaining count drops by exactly the bytes taken.
    p_rem_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && ch_en) |=> (!ch_en || (rem_q == $past(rem_q) - TOT_W'($past(take_bytes)))));

endmodule

// File: rtl/wa_hold_buf.sv
// Holding register: a byte queue that shifts consumed bytes out of lane 0
// and appends accepted source bytes behind the bytes still held.
// Assumes the caller never offers more bytes than there is room for.
module wa_hold_buf
    import dma_wa_pkg::*;
#(
    parameter int BUF_BYTES = 8,
    localparam int OCC_W = $clog2(BUF_BYTES + 1),
    localparam int IDX_W = $clog2(BUF_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 in_fire,
    input  logic [8*LANES-1:0]   in_data,
    input  logic [BC_W-1:0]      take_bytes,
    input  logic                 out_fire,
    input  logic [BC_W-1:0]      out_bytes,
    output logic [OCC_W-1:0]     occ,
    output logic [8*LANES-1:0]   head_word
);

    logic [7:0]       store_q [BUF_BYTES];
    logic [7:0]       store_d [BUF_BYTES];
    logic [OCC_W-1:0] occ_q;
    logic [OCC_W-1:0] occ_d;
    logic [OCC_W-1:0] drop_n;
    logic [OCC_W-1:0] keep_n;

    // Next buffer contents: shift out the sent bytes, append the new ones.
    always_comb begin
        drop_n = out_fire ? OCC_W'(out_bytes) : '0;
        keep_n = occ_q - drop_n;
        for (int i = 0; i < BUF_BYTES; i++) begin
            store_d[i] = 8'h00;
            if (i + int'(drop_n) < BUF_BYTES)
                store_d[i] = store_q[IDX_W'(i + int'(drop_n))];
        end
        if (in_fire) begin
            for (int k = 0; k < LANES; k++) begin
                if ((k < int'(take_bytes)) && (int'(keep_n) + k < BUF_BYTES))
                    store_d[IDX_W'(int'(keep_n) + k)] = in_data[8*k +: 8];
            end
        end
        occ_d = keep_n + (in_fire ? OCC_W'(take_bytes) : '0);
    end

    // Register the buffer; a clear empties it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            occ_q <= '0;
            for (int i = 0; i < BUF_BYTES; i++) store_q[i] <= 8'h00;
        end else begin
            occ_q <= occ_d;
            for (int i = 0; i < BUF_BYTES; i++) store_q[i] <= store_d[i];
        end
    end

    // Lowest lanes of the queue form the candidate destination word.
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_head
            assign head_word[8*g +: 8] = store_q[g];
        end
    endgenerate

    assign occ = occ_q;

    // R6: accepted bytes always fit next to the bytes already held.
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |-> ((OCC_W + 1)'(occ_q) + (OCC_W + 1)'(take_bytes) <= (OCC_W + 1)'(BUF_BYTES)));

    // R7: a clear leaves nothing behind.
    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (occ_q == '0));

endmodule

// File: rtl/dma_width_adapter.sv
// DMA width adapter top: joins configuration capture, source byte
// tracking and the holding register, and drives both handshakes.
// Assumes in_data is right-aligned; lanes above the source width are don't-care.
module dma_width_adapter
    import dma_wa_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int BUF_WORDS = 2,
    localparam int DATA_W    = 8 * LANES,
    localparam int BUF_BYTES = BUF_WORDS * LANES,
    localparam int OCC_W     = $clog2(BUF_BYTES + 1),
    localparam int TOT_W     = CNT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_en,
    input  logic              multi_mode,
    input  logic              mem_is_src,
    input  logic [1:0]        per_width,
    input  logic [1:0]        mem_width,
    input  logic [CNT_W-1:0]  item_count,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [LANES-1:0]  out_be
);

    logic              active;
    logic              start;
    logic [TOT_W-1:0]  total_now;
    logic [BC_W-1:0]   src_bytes;
    logic [BC_W-1:0]   dst_bytes;
    logic              rem_zero;
    logic [BC_W-1:0]   take_bytes;
    logic [OCC_W-1:0]  occ;
    logic [DATA_W-1:0] head_word;
    logic [BC_W-1:0]   out_bytes;
    logic              word_full;
    logic              tail_flush;
    logic              room_ok;
    logic              in_fire;
    logic              out_fire;

    wa_cfg_capture #(.CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .ch_en      (ch_en),
        .multi_mode (multi_mode),
        .mem_is_src (mem_is_src),
        .per_width  (per_width),
        .mem_width  (mem_width),
        .item_count (item_count),
        .active     (active),
        .start      (start),
        .total_now  (total_now),
        .src_bytes  (src_bytes),
        .dst_bytes  (dst_bytes)
    );

    wa_in_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .ch_en      (ch_en),
        .start      (start),
        .total_now  (total_now),
        .src_bytes  (src_bytes),
        .in_fire    (in_fire),
        .rem_zero   (rem_zero),
        .take_bytes (take_bytes)
    );

    wa_hold_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!ch_en),
        .in_fire    (in_fire),
        .in_data    (in_data),
        .take_bytes (take_bytes),
        .out_fire   (out_fire),
        .out_bytes  (out_bytes),
        .occ        (occ),
        .head_word  (head_word)
    );

    // Output decision: a full destination word, or the tail after the last source byte.
    always_comb begin
        word_full  = (occ >= OCC_W'(dst_bytes));
        tail_flush = rem_zero && (occ != '0);
        out_valid  = active && ch_en && (word_full || tail_flush);
        out_bytes  = word_full ? dst_bytes : BC_W'(occ);
    end

    // Source admission: room for the sized beat in the holding register.
    always_comb begin
        room_ok  = ((OCC_W + 1)'(occ) + (OCC_W + 1)'(take_bytes)) <= (OCC_W + 1)'(BUF_BYTES);
        in_ready = active && ch_en && !rem_zero && room_ok;
    end

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    // Byte enables and zeroed idle lanes of the destination word.
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign out_be[g]           = out_valid && (g < int'(out_bytes));
            assign out_data[8*g +: 8]  = out_be[g] ? head_word[8*g +: 8] : 8'h00;
        end
    endgenerate

    // R8: enables are a run of ones from lane 0, capped at the destination width.
    p_be_contig_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($onehot0(out_be + LANES'(1)) && (out_be != '0)
                       && ($countones(out_be) <= int'(dst_bytes))));

    // R11: a stalled beat holds still until taken or the channel drops.
    p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && ch_en) |=>
            (!ch_en || (out_valid && $stable(out_data) && $stable(out_be))));

    // R12: no source beat is taken once the byte total is used up.
    p_no_ready_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rem_zero |-> !in_ready);

endmodule

// File: tb/test_dma_width_adapter.sv
module test_dma_width_adapter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ch_en = 1'b0;
    logic        multi_mode = 1'b0;
    logic        mem_is_src = 1'b0;
    logic [1:0]  per_width = 2'b00;
    logic [1:0]  mem_width = 2'b00;
    logic [15:0] item_count = 16'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = 32'h0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic [3:0]  out_be;

    always #5 clk = ~clk;

    dma_width_adapter i_dma_width_adapter (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .multi_mode(multi_mode),
        .mem_is_src(mem_is_src), .per_width(per_width), .mem_width(mem_width),
        .item_count(item_count), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_be(out_be)
    );

    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    int          mon_mode = 1;      // 0 always ready, 1 pseudo-random, 2 stalled
    string       cur_req = "R2";
    logic [35:0] exp_q[$];
    logic [7:0]  cur_seed;
    int          cur_sb;
    int          cur_nb;
    logic [7:0]  lfsr = 8'h5B;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int wbytes(input logic [1:0] c);
        return (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : 4;
    endfunction

    function automatic logic [31:0] src_word(input logic [7:0] sd, input int k);
        logic [31:0] w;
        for (int j = 0; j < 4; j++) w[8*j +: 8] = sd + 8'(4*k + j);
        return w;
    endfunction

    // Program fields, compute the expected destination beats from R1-style sizing.
    task automatic setup(input logic [1:0] pw, input logic [1:0] mw, input logic mm,
                         input logic dir, input int cnt, input logic [7:0] sd,
                         input bit push, input string req);
        int pb, mb, sb, db, total;
        per_width = pw; mem_width = mw; multi_mode = mm; mem_is_src = dir;
        item_count = 16'(cnt); cur_seed = sd; cur_req = req;
        pb = wbytes(pw);
        mb = mm ? wbytes(mw) : pb;
        sb = dir ? mb : pb;
        db = dir ? pb : mb;
        total = cnt * pb;
        cur_sb = sb;
        cur_nb = (total + sb - 1) / sb;
        if (push) begin
            for (int w = 0; w < total; w += db) begin
                int n;
                logic [31:0] d;
                logic [3:0]  b;
                n = (total - w < db) ? total - w : db;
                d = 32'h0; b = 4'h0;
                for (int j = 0; j < n; j++) begin
                    int bi;
                    bi = w + j;
                    d[8*j +: 8] = sd + 8'(4*(bi / sb) + (bi % sb));
                    b[j] = 1'b1;
                end
                exp_q.push_back({b, d});
            end
        end
    endtask

    task automatic enable();
        @(negedge clk);
        ch_en = 1'b1;
    endtask

    // Offer source beats [first, last); optionally disturb the config at beat 1 (R10).
    task automatic feed(input int first, input int last, input bit disturb);
        int k;
        bit r;
        k = first;
        while (k < last) begin
            @(negedge clk);
            if (disturb && k == 1) begin
                per_width = ~per_width; mem_width = ~mem_width;
                multi_mode = ~multi_mode; mem_is_src = ~mem_is_src;
                item_count = 16'd3;
            end
            in_valid = 1'b1;
            in_data = src_word(cur_seed, k);
            #1 r = in_ready;
            @(posedge clk);
            if (r) k++;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        int t;
        t = 0;
        while (exp_q.size() != 0 && t < 3000) begin
            @(posedge clk);
            t++;
        end
        check(exp_q.size() == 0, req, "beats still missing", exp_q.size(), 0);
        exp_q.delete();
        repeat (4) @(negedge clk);
        #1 check(out_valid == 1'b0, "R4", "beat beyond byte total", out_valid, 0);
        @(negedge clk);
        ch_en = 1'b0;
        @(negedge clk);
    endtask

    // Monitor / scoreboard: drives out_ready, compares every accepted beat.
    initial begin
        bit          prev_stall;
        logic [31:0] prev_d;
        logic [3:0]  prev_b;
        prev_stall = 0; prev_d = '0; prev_b = '0;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = (mon_mode == 0) ? 1'b1 : (mon_mode == 2) ? 1'b0 : (lfsr[0] | lfsr[2]);
            #2;
            if (prev_stall && ch_en && out_valid)
                check(out_data == prev_d && out_be == prev_b, "R11", "stalled beat moved",
                      {out_be, out_data}, {prev_b, prev_d});
            prev_stall = out_valid && !out_ready && ch_en;
            prev_d = out_data; prev_b = out_be;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R4", "unexpected beat", {out_be, out_data}, 0);
                end else begin
                    logic [35:0] e;
                    e = exp_q.pop_front();
                    check({out_be, out_data} == e, cur_req, "beat {be,data}",
                          {out_be, out_data}, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int acc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1 check(in_ready == 0 && out_valid == 0, "R12", "outputs after reset",
                 {in_ready, out_valid}, 0);

        // R2 R5: 8-bit items packed into 32-bit words, 3-byte tail.
        setup(2'b00, 2'b10, 1, 0, 7, 8'h10, 1, "R2"); enable(); feed(0, cur_nb, 0); drain("R5");
        // R2 R5: 16 -> 32, tail of 2 bytes.
        setup(2'b01, 2'b10, 1, 0, 5, 8'h40, 1, "R5"); enable(); feed(0, cur_nb, 0); drain("R5");
        // R2: 32 -> 8 unpacking, lane order.
        setup(2'b10, 2'b00, 1, 0, 3, 8'h70, 1, "R2"); enable(); feed(0, cur_nb, 0); drain("R2");
        // R2: 32 -> 16 and 8 -> 16.
        setup(2'b10, 2'b01, 1, 0, 2, 8'h90, 1, "R2"); enable(); feed(0, cur_nb, 0); drain("R2");
        setup(2'b00, 2'b01, 1, 0, 3, 8'hA0, 1, "R8"); enable(); feed(0, cur_nb, 0); drain("R8");
        // R3: single-data mode ignores mem_width.
        setup(2'b01, 2'b10, 0, 0, 4, 8'hB0, 1, "R3"); enable(); feed(0, cur_nb, 0); drain("R3");
        // R9: memory source, 32-bit words split into bytes, last word trimmed.
        setup(2'b00, 2'b10, 1, 1, 6, 8'hC0, 1, "R9"); enable(); feed(0, cur_nb, 0); drain("R9");
        // R9: memory source 8-bit into 32-bit peripheral items.
        setup(2'b10, 2'b00, 1, 1, 2, 8'hD0, 1, "R9"); enable(); feed(0, cur_nb, 0); drain("R9");
        // R1: reserved code 2'b11 acts as 32-bit.
        setup(2'b11, 2'b00, 1, 0, 2, 8'hE0, 1, "R1"); enable(); feed(0, cur_nb, 0); drain("R1");
        // R10: config disturbed mid-transfer.
        setup(2'b00, 2'b10, 1, 0, 6, 8'h20, 1, "R10"); enable(); feed(0, cur_nb, 1); drain("R10");

        // R7: abort with a partial word held, then a fresh transfer.
        setup(2'b00, 2'b10, 1, 0, 8, 8'h30, 0, "R7"); enable(); feed(0, 3, 0);
        repeat (3) @(negedge clk);
        #1 check(out_valid == 0, "R5", "partial word emitted early", out_valid, 0);
        @(negedge clk); ch_en = 1'b0;
        repeat (2) @(negedge clk);
        #1 check(out_valid == 0 && in_ready == 0, "R7", "outputs while disabled",
                 {in_ready, out_valid}, 0);
        setup(2'b00, 2'b10, 1, 0, 4, 8'h50, 1, "R7"); enable(); feed(0, cur_nb, 0); drain("R7");

        // R12: item count of zero.
        setup(2'b00, 2'b10, 1, 0, 0, 8'h00, 0, "R12"); enable();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            #1 check(in_ready == 0 && out_valid == 0, "R12", "activity with zero count",
                     {in_ready, out_valid}, 0);
        end
        in_valid = 1'b0;
        @(negedge clk); ch_en = 1'b0; @(negedge clk);

        // R6: destination stalled; exactly eight bytes admitted.
        mon_mode = 2;
        setup(2'b00, 2'b10, 1, 0, 12, 8'h60, 1, "R6"); enable();
        acc = 0;
        for (int i = 0; i < 20; i++) begin
            bit r;
            @(negedge clk);
            in_valid = 1'b1;
            in_data = src_word(cur_seed, acc);
            #1 r = in_ready;
            @(posedge clk);
            if (r) acc++;
        end
        @(negedge clk); in_valid = 1'b0;
        check(acc == 8, "R6", "beats admitted under stall", acc, 8);
        mon_mode = 1;
        feed(acc, cur_nb, 0); drain("R6");

        // R11 R2: long random-stall run, 16 -> 8.
        setup(2'b01, 2'b00, 1, 0, 20, 8'h11, 1, "R11"); enable(); feed(0, cur_nb, 0); drain("R11");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule